// File: doc/BRIEF.md
# Timekeeping Counters with Alarms

This core keeps three counters advanced by a 256 Hz tick enable: a 40-bit real-time counter, a 40-bit interval timer and a 32-bit cycle counter. The tick enable is produced elsewhere from a 32.768 kHz reference. A sensed input line, already synchronized to `clk`, can start and stop the interval timer in auto mode. The same line clocks the cycle counter. In both uses the line only counts once it has held its level for a qualification delay, and a control bit picks a short or a long delay.

Each counter has an alarm compare register, a flag and an active-low interrupt enable. A single active-low interrupt output reports any enabled flag. A snapshot strobe copies all three counters into holding registers, and counter reads return those held values. Software reaches the block through a byte-wide register port: a write takes effect at once, and read data appears one cycle after the request.

Register map, with multi-byte values least significant byte first: 0x00 status, 0x01 control, 0x02-0x06 real-time counter, 0x07-0x0B interval timer, 0x0C-0x0F cycle counter, 0x10-0x14 real-time alarm, 0x15-0x19 interval alarm, 0x1A-0x1D cycle alarm.

Top module: `tkc_core`

## Requirements
- R1: After reset all counters and alarms are zero, status reads 0x38, control reads 0x00, and `irq_n` is 1.
- R2: With control bit 4 (oscillator enable) at 1, each tick adds one to the real-time counter. With bit 4 at 0, no counter advances and the qualification timer does not advance.
- R3: In manual mode (control bit 5 = 0), the interval timer counts ticks while control bit 6 is 0 and holds its value while bit 6 is 1.
- R4: In auto mode (control bit 5 = 1), the interval timer starts once the line has been high for the selected delay and stops once the line has been low for that delay. Ticks that fall inside the delay are not counted while the timer is stopped, and are still counted while it is running.
- R5: The cycle counter adds one on a falling edge of the line only if the preceding high time lasted at least the selected delay, measured in ticks.
- R6: Control bit 7 selects the delay: `LONG_TICKS` ticks when it is 1, `SHORT_TICKS` ticks when it is 0. Any change of line level restarts the qualification count.
- R7: A status flag is set when its counter advances to a value equal to its alarm register. Bit 0 is the real-time flag, bit 1 the interval flag and bit 2 the cycle flag.
- R8: Reading status (address 0x00) returns the flags as they stood before the read and then clears them. A flag set in the same cycle as the read remains set.
- R9: `irq_n` is 0 exactly while some flag is 1 and its enable bit is 0. Status bits 3, 4 and 5 are the enables for the real-time, interval and cycle flags; writes to status change only these bits.
- R10: A counter read returns the value captured at the most recent `snap` strobe and does not change as the live counter advances.
- R11: Writing a counter byte loads that byte of the live counter. The lowest address of each counter holds its least significant byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 256 Hz count enable, one clock wide |
| line_in | input | 1 | Sensed line, synchronized to clk |
| snap | input | 1 | Copies all counters into the holding registers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after rd_en |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status read can land in the same clock cycle as a tick that carries the real-time counter onto its alarm value. In that cycle the read tries to clear the flag while the match tries to set it. The bench sets up this collision by driving `tick` and a status read together when the counter sits one below its alarm. The collision passes when the read returns the flag as 0 and a second status read returns it as 1.

// File: rtl/tkc_core.sv
module tkc_core #(
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  input  logic       snap,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n
);
  localparam int RT_W  = 40;
  localparam int IT_W  = 40;
  localparam int CC_W  = 32;
  localparam int RT_B  = RT_W / 8;
  localparam int IT_B  = IT_W / 8;
  localparam int CC_B  = CC_W / 8;
  localparam int RT_A  = 2;
  localparam int IT_A  = RT_A + RT_B;
  localparam int CC_A  = IT_A + IT_B;
  localparam int ART_A = CC_A + CC_B;
  localparam int AIT_A = ART_A + RT_B;
  localparam int ACC_A = AIT_A + IT_B;
  localparam int QW    = $clog2(LONG_TICKS + 1);

  logic [RT_W-1:0] rt, h_rt, a_rt;
  logic [IT_W-1:0] it, h_it, a_it;
  logic [CC_W-1:0] cc, h_cc, a_cc;
  logic [2:0] flags, ien;
  logic osc, auto_m, stop, dsel;
  logic line_d, q_run;
  logic [QW-1:0] qcnt, lim;
  logic [7:0] rd_mux;

  wire tk      = tick & osc;
  wire chg     = line_in ^ line_d;
  wire fall    = line_d & ~line_in;
  wire qual    = qcnt >= lim;
  wire it_inc  = tk & (auto_m ? q_run : ~stop);
  wire cc_inc  = osc & fall & qual;
  wire rd_stat = rd_en && addr == 5'd0;
  wire wr_cnt  = wr_en && addr >= 5'(RT_A) && addr < 5'(ART_A);
  wire [2:0] set_f = {cc_inc && (cc + 1'b1) == a_cc,
                      it_inc && (it + 1'b1) == a_it,
                      tk && (rt + 1'b1) == a_rt};

  assign lim   = dsel ? QW'(LONG_TICKS) : QW'(SHORT_TICKS);
  assign irq_n = ~|(flags & ~ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d <= 1'b0;
      qcnt   <= '0;
      q_run  <= 1'b0;
    end else begin
      line_d <= line_in;
      if (chg) qcnt <= '0;
      else if (tk && !qual) qcnt <= qcnt + 1'b1;
      if (!chg && qual) q_run <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt <= '0; it <= '0; cc <= '0;
      a_rt <= '0; a_it <= '0; a_cc <= '0;
      {dsel, stop, auto_m, osc} <= 4'b0;
      ien   <= 3'b111;
      flags <= 3'b0;
    end else begin
      if (tk) rt <= rt + 1'b1;
      if (it_inc) it <= it + 1'b1;
      if (cc_inc) cc <= cc + 1'b1;
      flags <= (flags & ~{3{rd_stat}}) | set_f;
      if (wr_en) begin
        if (addr == 5'd0) ien <= wdata[5:3];
        if (addr == 5'd1) {dsel, stop, auto_m, osc} <= wdata[7:4];
        for (int i = 0; i < RT_B; i++) begin
          if (addr == 5'(RT_A + i))  rt[8*i +: 8]   <= wdata;
          if (addr == 5'(ART_A + i)) a_rt[8*i +: 8] <= wdata;
        end
        for (int i = 0; i < IT_B; i++) begin
          if (addr == 5'(IT_A + i))  it[8*i +: 8]   <= wdata;
          if (addr == 5'(AIT_A + i)) a_it[8*i +: 8] <= wdata;
        end
        for (int i = 0; i < CC_B; i++) begin
          if (addr == 5'(CC_A + i))  cc[8*i +: 8]   <= wdata;
          if (addr == 5'(ACC_A + i)) a_cc[8*i +: 8] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rt <= '0; h_it <= '0; h_cc <= '0;
    end else if (snap) begin
      h_rt <= rt; h_it <= it; h_cc <= cc;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == 5'd0) rd_mux = {2'b00, ien, flags};
    if (addr == 5'd1) rd_mux = {dsel, stop, auto_m, osc, 4'b0};
    for (int i = 0; i < RT_B; i++) begin
      if (addr == 5'(RT_A + i))  rd_mux = h_rt[8*i +: 8];
      if (addr == 5'(ART_A + i)) rd_mux = a_rt[8*i +: 8];
    end
    for (int i = 0; i < IT_B; i++) begin
      if (addr == 5'(IT_A + i))  rd_mux = h_it[8*i +: 8];
      if (addr == 5'(AIT_A + i)) rd_mux = a_it[8*i +: 8];
    end
    for (int i = 0; i < CC_B; i++) begin
      if (addr == 5'(CC_A + i))  rd_mux = h_cc[8*i +: 8];
      if (addr == 5'(ACC_A + i)) rd_mux = a_cc[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_OSC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc && !wr_cnt) |=> ($stable(rt) && $stable(it) && $stable(cc))); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_m && stop && !wr_cnt) |=> $stable(it)); // R3
  AST_CC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cc == $past(cc) || cc == $past(cc) + 32'd1)); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && set_f == 3'b0) |=> flags == 3'b0); // R8
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    set_f[0] |=> flags[0]); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> |flags); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> ($stable(h_rt) && $stable(h_it) && $stable(h_cc))); // R10
endmodule

// File: tb/tkc_core_tb.sv
module tkc_core_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, line_in = 0, snap = 0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_n;
  int n_chk = 0, n_fail = 0;

  tkc_core dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
    .snap(snap), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic set_line(input logic v);
    @(negedge clk); line_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_cnt(input logic [4:0] base, input int nb, output logic [63:0] v);
    logic [7:0] b;
    @(negedge clk); snap = 1;
    @(negedge clk); snap = 0;
    v = '0;
    for (int i = 0; i < nb; i++) begin
      rd(base + 5'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic t_reset;
    logic [7:0] b;
    logic [63:0] v;
    rd(5'd0, b); chk("R1 status", b, 8'h38);
    rd(5'd1, b); chk("R1 control", b, 8'h00);
    rd_cnt(5'd2, 5, v); chk("R1 rtc", v, 0);
    chk("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_bytes;
    logic [63:0] v;
    for (int i = 0; i < 5; i++) wr(5'd2 + 5'(i), 8'h11 * 8'(i + 1));
    rd_cnt(5'd2, 5, v); chk("R11 rtc byte order", v, 64'h5544332211);
  endtask

  task automatic t_osc;
    logic [63:0] v;
    ticks(3);
    rd_cnt(5'd2, 5, v); chk("R2 osc off holds", v, 64'h5544332211);
    wr(5'd1, 8'h50);
    ticks(4);
    rd_cnt(5'd2, 5, v); chk("R2 rtc counts", v, 64'h5544332215);
  endtask

  task automatic t_manual;
    logic [63:0] a, b;
    rd_cnt(5'd7, 5, a);
    wr(5'd1, 8'h10);
    ticks(3);
    rd_cnt(5'd7, 5, b); chk("R3 run", b - a, 3);
    wr(5'd1, 8'h50);
    ticks(3);
    rd_cnt(5'd7, 5, a); chk("R3 stop", a - b, 0);
  endtask

  task automatic t_auto;
    logic [63:0] a, b, c0, c1;
    wr(5'd1, 8'h30);
    rd_cnt(5'd7, 5, a);
    ticks(3);
    rd_cnt(5'd7, 5, b); chk("R4 idle low", b - a, 0);
    rd_cnt(5'd12, 4, c0);
    set_line(1);
    ticks(5);
    rd_cnt(5'd7, 5, a); chk("R4 start after delay", a - b, 4);
    set_line(0);
    rd_cnt(5'd12, 4, c1); chk("R5 qualified fall", c1 - c0, 1);
    ticks(5);
    rd_cnt(5'd7, 5, b); chk("R4 stop after delay", b - a, 1);
    set_line(1);
    set_line(0);
    rd_cnt(5'd12, 4, c0); chk("R5 short high ignored", c0 - c1, 0);
  endtask

  task automatic t_dsel;
    logic [63:0] a, b;
    wr(5'd1, 8'hD0);
    rd_cnt(5'd12, 4, a);
    set_line(1); ticks(31); set_line(0);
    rd_cnt(5'd12, 4, b); chk("R6 long delay not met", b - a, 0);
    set_line(1); ticks(32); set_line(0);
    rd_cnt(5'd12, 4, a); chk("R6 long delay met", a - b, 1);
  endtask

  task automatic t_alarm;
    logic [7:0] s;
    wr(5'd1, 8'h40);
    for (int i = 0; i < 5; i++) wr(5'd2 + 5'(i), 8'h00);
    wr(5'd16, 8'h03);
    rd(5'd0, s);
    wr(5'd1, 8'h50);
    ticks(2);
    rd(5'd0, s); chk("R7 no flag yet", s, 8'h38);
    ticks(1);
    chk("R9 disabled irq", irq_n, 1);
    wr(5'd0, 8'h37);
    chk("R9 enabled irq", irq_n, 0);
    rd(5'd0, s); chk("R7 rtc flag bit0", s, 8'h31);
    chk("R9 irq released", irq_n, 1);
    rd(5'd0, s); chk("R8 cleared", s, 8'h30);
  endtask

  task automatic t_collide;
    logic [7:0] s;
    wr(5'd16, 8'h05);
    ticks(1);
    rd(5'd0, s);
    @(negedge clk); tick = 1; rd_en = 1; addr = 5'd0;
    @(negedge clk); tick = 0; rd_en = 0; s = rdata;
    chk("R8 read in set cycle", s, 8'h30);
    rd(5'd0, s); chk("R8 flag survives", s, 8'h31);
  endtask

  task automatic t_snap;
    logic [63:0] v;
    logic [7:0] b;
    rd_cnt(5'd2, 5, v);
    ticks(2);
    rd(5'd2, b); chk("R10 held value", b, v[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_bytes;
    t_osc;
    t_manual;
    t_auto;
    t_dsel;
    t_alarm;
    t_collide;
    t_snap;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule